// File: doc/BRIEF.md
# Bus-Mapped Configurable GPIO Pair

This block provides two 8-bit general-purpose I/O ports, A and B, on a simple data-memory bus with address, write data, a write strobe, a read strobe and read data. Each port holds a data byte and a configuration byte. Each port also has a read-only location that returns the synchronized level of its pins. For every pin, the two stored bits choose the pad mode: floating input, input with weak pull-up, drive low or drive high. The block drives the output-enable, output-value and pull-up-enable signals of the external pad cells directly.

Pins 6 and 7 of port B are input-only. The block refuses configuration writes to those two bits, and they always read back as zero. Any write that sets bit 7 of port B's data byte also raises a single-cycle halt request for the surrounding system. The bus never stalls: every access completes in a fixed number of cycles. Because there is no back-pressure, there are no valid/ready signals, and the strobes act as single-cycle commands.

Top module: `gpio_bus_ports`

## Requirements
- R1: Pad signals for each pin. Output enable equals the configuration bit, and output value equals the data bit. Pull-up enable is 1 only when the configuration bit is 0 and the data bit is 1.
- R2: Address map for port A: data at 0xD0, configuration at 0xD1, pins at 0xD2. Port B uses 0xD4, 0xD5 and 0xD6 in the same way. Reads of any other address, including 0xD3 and 0xD7, return 0x00. Writes to any other address change nothing.
- R3: Read data comes from a register and is valid one clock after the edge that samples the read strobe. It returns the value held before any write at that same edge. In cycles with no read strobe, read data is 0x00.
- R4: A write updates the addressed data or configuration byte on the edge that samples the write strobe. That byte reads back exactly as written, so software can set or clear any single bit with read-modify-write.
- R5: The pins location returns pin levels delayed by two synchronizing flops. A pin change before edge k is returned by a read sampled at edge k+2. Writes to the pins location are ignored.
- R6: Port B configuration bits 6 and 7 ignore writes of 1 and always read 0. Output enable for those two pins is always 0.
- R7: A write to 0xD4 with bit 7 of the write data set gives halt_req = 1 for exactly the following cycle. The stored bit 7 stays readable. A write with bit 7 clear gives no pulse.
- R8: Reset is active-low and asynchronous. It clears every data and configuration byte, the synchronizer flops, halt_req and read data, so every pin is a floating input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pa_pin | input | 8 | Port A pad input levels |
| pa_oe | output | 8 | Port A output enables |
| pa_drv | output | 8 | Port A output values |
| pa_pu | output | 8 | Port A pull-up enables |
| pb_pin | input | 8 | Port B pad input levels |
| pb_oe | output | 8 | Port B output enables |
| pb_drv | output | 8 | Port B output values |
| pb_pu | output | 8 | Port B pull-up enables |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The block's results fall due at three different times:
- **Pad signals** follow a write on the same edge, so they are checked just after that edge.
- **Read data and the halt pulse** are each one register away from the edge that samples the strobe.
- **Pin levels** need two more edges before a read can capture them.

The bench drives inputs once per cycle and advances a behavioural model at each edge. That model keeps the pre-write value for a read at the same edge and has its own two-entry pin history. A quarter period after the edge, the bench compares every output against the model, so each result is checked in exactly the cycle it falls due.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NPORTS    = 2,
  parameter int STRIDE    = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hD0
) (
  input  logic [ADDR_W-1:0]                       addr,
  output logic                                    hit,
  output logic [(NPORTS > 1 ? $clog2(NPORTS) : 1)-1:0] port_idx,
  output reg_sel_e                                sel
);
  localparam int SUB_W = $clog2(STRIDE);
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NPORTS * STRIDE);

  logic [ADDR_W-1:0] off;
  logic [SUB_W-1:0]  sub;

  always_comb begin
    off      = addr - BASE_ADDR;
    hit      = (addr >= BASE_ADDR) && (off < SPAN);
    port_idx = off[SUB_W +: IDX_W];
    sub      = off[SUB_W-1:0];
    if (!hit)
      sel = SEL_NONE;
    else begin
      case (sub)
        SUB_W'(0): sel = SEL_DATA;
        SUB_W'(1): sel = SEL_CFG;
        SUB_W'(2): sel = SEL_PINS;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int         W           = 8,
  parameter logic [W-1:0] IN_ONLY   = '0,
  parameter bit         HALT_EN     = 1'b0,
  parameter int         HALT_BIT    = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_cfg,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] drv,
  output logic [W-1:0] pu,
  output logic         halt_set
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_cfg)  cfg_q  <= wdata & ~IN_ONLY;
    end
  end

  always_comb begin
    oe  = cfg_q;
    drv = data_q;
    pu  = ~cfg_q & data_q;
  end

  generate
    if (HALT_EN) begin : g_halt
      assign halt_set = wr_data & wdata[HALT_BIT];
    end else begin : g_nohalt
      assign halt_set = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_bus_ports.sv
module gpio_bus_ports
  import gpio_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         W          = 8,
  parameter logic [7:0] BASE_ADDR  = 8'hD0,
  parameter int         STRIDE     = 4,
  parameter logic [7:0] PB_IN_ONLY = 8'hC0,
  parameter int         HALT_BIT   = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pa_pin,
  output logic [W-1:0]      pa_oe,
  output logic [W-1:0]      pa_drv,
  output logic [W-1:0]      pa_pu,
  input  logic [W-1:0]      pb_pin,
  output logic [W-1:0]      pb_oe,
  output logic [W-1:0]      pb_drv,
  output logic [W-1:0]      pb_pu,
  output logic              halt_req
);
  localparam int NPORTS = 2;
  localparam int IDX_W  = $clog2(NPORTS);

  logic              hit;
  logic [IDX_W-1:0]  idx;
  reg_sel_e          sel;

  logic [NPORTS-1:0][W-1:0] data_q, cfg_q, oe, drv, pu, pins_s, pins_raw;
  logic [NPORTS-1:0]        halt_set;

  gpio_addr_dec #(
    .ADDR_W(ADDR_W), .NPORTS(NPORTS), .STRIDE(STRIDE),
    .BASE_ADDR(ADDR_W'(BASE_ADDR))
  ) u_dec (
    .addr(bus_addr), .hit(hit), .port_idx(idx), .sel(sel)
  );

  assign pins_raw[0] = pa_pin;
  assign pins_raw[1] = pb_pin;

  gpio_sync #(.W(NPORTS*W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  genvar p;
  generate
    for (p = 0; p < NPORTS; p++) begin : g_port
      localparam logic [W-1:0] MASK = (p == 1) ? W'(PB_IN_ONLY) : '0;
      logic wr_d, wr_c;
      assign wr_d = bus_wr && hit && (idx == IDX_W'(p)) && (sel == SEL_DATA);
      assign wr_c = bus_wr && hit && (idx == IDX_W'(p)) && (sel == SEL_CFG);
      gpio_port_regs #(
        .W(W), .IN_ONLY(MASK), .HALT_EN(p == 1), .HALT_BIT(HALT_BIT)
      ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_d), .wr_cfg(wr_c),
        .wdata(bus_wdata), .data_q(data_q[p]), .cfg_q(cfg_q[p]),
        .oe(oe[p]), .drv(drv[p]), .pu(pu[p]), .halt_set(halt_set[p])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      halt_req  <= 1'b0;
    end else begin
      halt_req <= |halt_set;
      if (bus_rd && hit) begin
        case (sel)
          SEL_DATA: bus_rdata <= data_q[idx];
          SEL_CFG:  bus_rdata <= cfg_q[idx];
          SEL_PINS: bus_rdata <= pins_s[idx];
          default:  bus_rdata <= '0;
        endcase
      end else begin
        bus_rdata <= '0;
      end
    end
  end

  assign pa_oe  = oe[0];
  assign pa_drv = drv[0];
  assign pa_pu  = pu[0];
  assign pb_oe  = oe[1];
  assign pb_drv = drv[1];
  assign pb_pu  = pu[1];
endmodule

// File: rtl/gpio_bus_ports_chk.sv
module gpio_bus_ports_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [7:0] pa_oe,
  input logic [7:0] pa_drv,
  input logic [7:0] pa_pu,
  input logic [7:0] pb_oe,
  input logic [7:0] pb_drv,
  input logic [7:0] pb_pu,
  input logic       halt_req
);
  // R1: pull-up and drive never both active on a pin
  p_pu_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_pu & pa_oe) == 8'h00) && ((pb_pu & pb_oe) == 8'h00));

  // R2: unmapped read returns zero next cycle
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 8'hD3 || bus_addr == 8'hD7)) |=> (bus_rdata == 8'h00));

  // R3: no read strobe, no read data
  p_idle_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 8'h00));

  // R4: data write lands on the pad value at the next sample
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hD0) |=> (pa_drv == $past(bus_wdata)));

  // R6: input-only pins never enabled
  p_in_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_oe[7:6] == 2'b00));

  // R7: halt pulse only after a setting write
  p_halt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_wr && bus_addr == 8'hD4 && bus_wdata[7]));

  // R8: outputs quiet while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r8: assert ((pa_oe | pb_oe | pa_pu | pb_pu) == 8'h00 && !halt_req);
    end
  end
endmodule

bind gpio_bus_ports gpio_bus_ports_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pa_oe(pa_oe), .pa_drv(pa_drv), .pa_pu(pa_pu),
  .pb_oe(pb_oe), .pb_drv(pb_drv), .pb_pu(pb_pu), .halt_req(halt_req)
);

// File: tb/gpio_bus_ports_bench.sv
module gpio_bus_ports_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_pin = '0, pb_pin = '0;
  logic [7:0] pa_oe, pa_drv, pa_pu, pb_oe, pb_drv, pb_pu;
  logic       halt_req;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_da, m_ca, m_db, m_cb;
  int m_rd, m_halt;
  int hist_a[$], hist_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bus_ports u_gpio_bus_ports (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pa_pin(pa_pin), .pa_oe(pa_oe), .pa_drv(pa_drv), .pa_pu(pa_pu),
    .pb_pin(pb_pin), .pb_oe(pb_oe), .pb_drv(pb_drv), .pb_pu(pb_pu),
    .halt_req(halt_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_da = 0; m_ca = 0; m_db = 0; m_cb = 0; m_rd = 0; m_halt = 0;
    hist_a = '{0, 0};
    hist_b = '{0, 0};
  endtask

  // advance the model for one rising edge using the current inputs
  task automatic model_edge();
    int a, w;
    a = int'(bus_addr);
    w = int'(bus_wdata);
    if (!rst_n) begin model_reset(); return; end
    m_rd = 0;
    if (bus_rd) begin
      if      (a == 'hD0) m_rd = m_da;
      else if (a == 'hD1) m_rd = m_ca;
      else if (a == 'hD2) m_rd = hist_a[0];
      else if (a == 'hD4) m_rd = m_db;
      else if (a == 'hD5) m_rd = m_cb;
      else if (a == 'hD6) m_rd = hist_b[0];
    end
    m_halt = (bus_wr && a == 'hD4 && w >= 128) ? 1 : 0;
    if (bus_wr) begin
      if      (a == 'hD0) m_da = w;
      else if (a == 'hD1) m_ca = w;
      else if (a == 'hD4) m_db = w;
      else if (a == 'hD5) m_cb = w % 64;
    end
    void'(hist_a.pop_front()); hist_a.push_back(int'(pa_pin));
    void'(hist_b.pop_front()); hist_b.push_back(int'(pb_pin));
  endtask

  function automatic int pu_of(int c, int d);
    int r = 0;
    for (int i = 0; i < 8; i++)
      if (((c >> i) & 1) == 0 && ((d >> i) & 1) == 1) r += (1 << i);
    return r;
  endfunction

  task automatic compare_all();
    chk(int'(bus_rdata) == m_rd, "R3 rdata", int'(bus_rdata), m_rd);
    chk(int'(pa_oe) == m_ca && int'(pa_drv) == m_da, "R1 port A oe/drv",
        int'({pa_oe, pa_drv}), m_ca * 256 + m_da);
    chk(int'(pb_oe) == m_cb && int'(pb_drv) == m_db, "R1 port B oe/drv",
        int'({pb_oe, pb_drv}), m_cb * 256 + m_db);
    chk(int'(pa_pu) == pu_of(m_ca, m_da), "R1 port A pull-up", int'(pa_pu), pu_of(m_ca, m_da));
    chk(int'(pb_pu) == pu_of(m_cb, m_db), "R1 port B pull-up", int'(pb_pu), pu_of(m_cb, m_db));
    chk(int'(halt_req) == m_halt, "R7 halt_req", int'(halt_req), m_halt);
  endtask

  // one cycle: inputs already set; edge, model, then compare off-edge
  task automatic cycle();
    @(posedge clk);
    model_edge();
    #(CLK_PERIOD/4);
    compare_all();
  endtask

  task automatic bus(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    cycle();
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    cycle(); cycle();
    // R8: reset state
    chk(pa_oe == 0 && pb_oe == 0 && pa_pu == 0 && pb_pu == 0 && halt_req == 0 && bus_rdata == 0,
        "R8 reset state", int'(pa_oe | pb_oe | pa_pu | pb_pu), 0);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    cycle();

    // R4/R1: write and read back, one-clock read latency
    bus(1, 0, 8'hD0, 8'hA5);
    bus(1, 0, 8'hD1, 8'h0F);
    chk(pa_oe == 8'h0F && pa_drv == 8'hA5 && pa_pu == 8'hA0, "R1 mode mix",
        int'(pa_pu), 'hA0);
    bus(0, 1, 8'hD1, 8'h00);
    chk(bus_rdata == 8'h0F, "R4 cfg readback", int'(bus_rdata), 'h0F);
    // R3: read at same edge as a write returns old value
    bus(1, 1, 8'hD0, 8'h3C);
    chk(bus_rdata == 8'hA5, "R3 read before write", int'(bus_rdata), 'hA5);
    bus(0, 0, 8'h00, 8'h00);
    chk(bus_rdata == 8'h00, "R3 idle zero", int'(bus_rdata), 0);

    // R6: input-only config bits
    bus(1, 0, 8'hD5, 8'hFF);
    bus(0, 1, 8'hD5, 8'h00);
    chk(bus_rdata == 8'h3F && pb_oe == 8'h3F, "R6 masked cfg", int'(bus_rdata), 'h3F);

    // R7: halt pulse and readable bit 7
    bus(1, 0, 8'hD4, 8'h80);
    chk(halt_req == 1'b1, "R7 halt pulse", int'(halt_req), 1);
    bus(0, 1, 8'hD4, 8'h00);
    chk(halt_req == 1'b0 && bus_rdata == 8'h80, "R7 single cycle and stored bit",
        int'({halt_req, bus_rdata}), 'h80);
    bus(1, 0, 8'hD4, 8'h7F);
    chk(halt_req == 1'b0, "R7 no pulse on bit7 clear", int'(halt_req), 0);
    bus(1, 0, 8'hD0, 8'h80);
    chk(halt_req == 1'b0, "R7 port A bit7 no pulse", int'(halt_req), 0);

    // R2: unmapped writes change nothing, reads zero
    bus(1, 0, 8'hD3, 8'hFF);
    bus(1, 0, 8'hD7, 8'hFF);
    bus(1, 0, 8'hD8, 8'hFF);
    bus(1, 0, 8'hCF, 8'hFF);
    chk(pa_oe == 8'h0F && pb_oe == 8'h3F, "R2 unmapped write ignored",
        int'({pa_oe, pb_oe}), 'h0F3F);
    bus(0, 1, 8'hD7, 8'h00);
    chk(bus_rdata == 8'h00, "R2 unmapped read zero", int'(bus_rdata), 0);

    // R5: two-flop synchronizer timing and pins location write ignored
    pa_pin = 8'h5A;
    cycle();
    bus(0, 1, 8'hD2, 8'h00);
    chk(bus_rdata == 8'h00, "R5 too early", int'(bus_rdata), 0);
    bus(0, 1, 8'hD2, 8'h00);
    chk(bus_rdata == 8'h5A, "R5 synced level", int'(bus_rdata), 'h5A);
    bus(1, 0, 8'hD2, 8'h00);
    bus(0, 1, 8'hD2, 8'h00);
    chk(bus_rdata == 8'h5A, "R5 pins write ignored", int'(bus_rdata), 'h5A);

    // random traffic, model compared every cycle (R1 R2 R3 R4 R5 R6 R7)
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pick [10] = '{8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5, 8'hD6, 8'hD7, 8'hD8, 8'h10};
      pa_pin = 8'($urandom);
      pb_pin = 8'($urandom);
      bus_addr = pick[$urandom % 10];
      bus_wdata = 8'($urandom);
      bus_wr = 1'($urandom);
      bus_rd = 1'($urandom);
      cycle();
    end
    bus_wr = 0; bus_rd = 0;

    // R8: asynchronous reset mid-run clears everything
    #(CLK_PERIOD/8);
    rst_n = 1'b0;
    #1;
    chk(pa_oe == 0 && pb_oe == 0 && pa_drv == 0 && pb_drv == 0 && bus_rdata == 0,
        "R8 async clear", int'(pa_drv | pb_drv), 0);
    model_reset();
    cycle();
    rst_n = 1'b1;
    cycle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule